// File: doc/BRIEF.md
# Combining Prefix-Sum Unit

This block keeps a small bank of base registers and serves atomic fetch-and-add operations from many requesters in the same cycle. Each requester offers a valid flag, the index of the base register it targets and a one-bit increment. Requests that hit the same base are not queued one behind another. They are folded into one multi-operand prefix computation. Every requester gets the value the base would have shown had the requests been applied one at a time in ascending requester order. The base then moves forward by the total of all increments, in that same cycle.

Requests that target different bases are handled side by side, with no interaction. A separate write port lets the controlling core load a base directly. When that write lands in the same cycle as requests to the same base, the written value is used as the starting point for those requests. Responses come back exactly one cycle after the request, each with its own valid flag. Base arithmetic wraps modulo the register width. Software can read a base by issuing a request with a zero increment.

Top module: `psu_combine_top`

## Requirements
- R1: After reset every base register holds zero and every response valid flag is low.
- R2: A lone request with increment 1 returns the old base value, and the base is one larger afterwards.
- R3: For requesters aiming at the same base in one cycle, requester i receives that cycle's starting value plus the number of valid requesters with index below i that target the same base with increment 1. The base then grows by the count of all such increments.
- R4: Among requesters that hit the same base in one cycle with increment 1, no two receive the same value.
- R5: Requests to different bases in the same cycle are served independently, and every one of them completes in that cycle.
- R6: A direct write to a base in the same cycle as requests to that base takes priority. Those requests are answered from the written value, and the base ends at the written value plus the increment count.
- R7: Each response valid flag equals the requester's valid input from one cycle earlier. An invalid request changes no base, even when its increment input is 1.
- R8: Base values and returned values wrap modulo 2^DW (16 bits by default).
- R9: A valid request with increment 0 receives the running prefix value at its position and adds nothing to the base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | N_REQ | Request present, one bit per requester |
| req_idx | input | N_REQ*IW | Base index per requester; requester i uses bits [i*IW +: IW] |
| req_inc | input | N_REQ | Increment per requester, 0 or 1 |
| wr_en | input | 1 | Direct base write enable |
| wr_idx | input | IW | Base index for the direct write |
| wr_data | input | DW | Value for the direct write |
| rsp_valid | output | N_REQ | Response present, one cycle after the request |
| rsp_val | output | N_REQ*DW | Returned value per requester; requester i at bits [i*DW +: DW] |

## Verification
The assertions take every base index to be below N_BASE, since an index past the bank would select nothing meaningful. They also assume that N_REQ is far smaller than 2^DW, so values returned in one cycle cannot wrap onto each other. The random stimulus draws indices only from the populated range and keeps the default width. It mixes dense same-base bursts, zero increments, invalid requests with their increment bit set, and occasional direct writes that collide with requests. Directed cases cover preloading a base just below the wrap point and writing a base while it is being hit.

// File: rtl/psu_pkg.sv
package psu_pkg;

    // Bit count needed to index n items; never below one.
    function automatic int unsigned idx_bits(input int unsigned n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

    // Bit count needed to hold the values 0..n.
    function automatic int unsigned cnt_bits(input int unsigned n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/psu_route.sv
// Splits requests into one activity mask per base register.
module psu_route #(
    parameter int N_REQ  = 8,
    parameter int N_BASE = 4,
    parameter int IW     = 2
) (
    input  logic [N_REQ-1:0]        req_valid,
    input  logic [N_REQ*IW-1:0]     req_idx,
    input  logic [N_REQ-1:0]        req_inc,
    output logic [N_BASE*N_REQ-1:0] act_map
);

    always_comb begin
        for (int k = 0; k < N_BASE; k++) begin
            for (int i = 0; i < N_REQ; i++) begin
                act_map[k*N_REQ + i] = req_valid[i] && req_inc[i]
                                       && (req_idx[i*IW +: IW] == IW'(k));
            end
        end
    end

endmodule

// File: rtl/psu_lane.sv
// Exclusive prefix count over one base's activity mask.
module psu_lane #(
    parameter int N_REQ = 8,
    parameter int CW    = 4,
    parameter bit TREE  = 1'b1
) (
    input  logic [N_REQ-1:0]    act,
    output logic [N_REQ*CW-1:0] excl,
    output logic [CW-1:0]       total
);

    localparam int STG = (N_REQ <= 1) ? 0 : $clog2(N_REQ);

    logic [CW-1:0] incl [N_REQ];

    generate
        if (TREE) begin : g_tree
            logic [CW-1:0] lvl [STG+1][N_REQ];
            always_comb begin
                for (int i = 0; i < N_REQ; i++) begin
                    lvl[0][i] = CW'(act[i]);
                end
                for (int s = 0; s < STG; s++) begin
                    for (int i = 0; i < N_REQ; i++) begin
                        if (i >= (1 << s)) begin
                            lvl[s+1][i] = lvl[s][i] + lvl[s][i - (1 << s)];
                        end else begin
                            lvl[s+1][i] = lvl[s][i];
                        end
                    end
                end
                for (int i = 0; i < N_REQ; i++) begin
                    incl[i] = lvl[STG][i];
                end
            end
        end else begin : g_ripple
            always_comb begin
                logic [CW-1:0] run;
                run = '0;
                for (int i = 0; i < N_REQ; i++) begin
                    run     = run + CW'(act[i]);
                    incl[i] = run;
                end
            end
        end
    endgenerate

    always_comb begin
        for (int i = 0; i < N_REQ; i++) begin
            excl[i*CW +: CW] = incl[i] - CW'(act[i]);
        end
        total = incl[N_REQ-1];
    end

    // The scan's last element must agree with a plain population count.
    always_comb begin
        assert_total_count_R3: assert (32'(total) == $countones(act));
    end

endmodule

// File: rtl/psu_bank.sv
// Base register bank with same-cycle write override.
module psu_bank #(
    parameter int N_BASE = 4,
    parameter int DW     = 16,
    parameter int IW     = 2,
    parameter int CW     = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [IW-1:0]           wr_idx,
    input  logic [DW-1:0]           wr_data,
    input  logic [N_BASE*CW-1:0]    total_flat,
    output logic [N_BASE*DW-1:0]    eff_flat
);

    typedef struct packed {
        logic                         live;
        logic [N_BASE-1:0][DW-1:0]    base;
    } bank_st_t;

    bank_st_t st_d, st_q;

    logic [CW-1:0]     total [N_BASE];
    logic [N_BASE-1:0] wr_hit;

    always_comb begin
        st_d      = st_q;
        st_d.live = 1'b1;
        for (int k = 0; k < N_BASE; k++) begin
            total[k]  = total_flat[k*CW +: CW];
            wr_hit[k] = wr_en && (wr_idx == IW'(k));
            eff_flat[k*DW +: DW] = wr_hit[k] ? wr_data : st_q.base[k];
            st_d.base[k] = eff_flat[k*DW +: DW] + DW'(total[k]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    generate
        for (genvar k = 0; k < N_BASE; k++) begin : g_chk
            assert_base_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (st_q.live && $past(!wr_hit[k]))
                |-> st_q.base[k] == DW'($past(st_q.base[k]) + DW'($past(total[k]))));

            assert_write_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (st_q.live && $past(wr_hit[k]))
                |-> st_q.base[k] == DW'($past(wr_data) + DW'($past(total[k]))));

            assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (st_q.live && $past(!wr_hit[k] && total[k] == '0))
                |-> $stable(st_q.base[k]));
        end
    endgenerate

endmodule

// File: rtl/psu_combine_top.sv
// Combining multi-operand prefix-sum unit, top level.
module psu_combine_top #(
    parameter int N_REQ  = 8,
    parameter int N_BASE = 4,
    parameter int DW     = 16,
    parameter bit TREE   = 1'b1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [N_REQ-1:0]                 req_valid,
    input  logic [N_REQ*psu_pkg::idx_bits(N_BASE)-1:0] req_idx,
    input  logic [N_REQ-1:0]                 req_inc,
    input  logic                             wr_en,
    input  logic [psu_pkg::idx_bits(N_BASE)-1:0] wr_idx,
    input  logic [DW-1:0]                    wr_data,
    output logic [N_REQ-1:0]                 rsp_valid,
    output logic [N_REQ*DW-1:0]              rsp_val
);

    localparam int IW = psu_pkg::idx_bits(N_BASE);
    localparam int CW = psu_pkg::cnt_bits(N_REQ);

    typedef struct packed {
        logic                        live;
        logic [N_REQ-1:0]            vld;
        logic [N_REQ-1:0][DW-1:0]    val;
    } rsp_st_t;

    rsp_st_t st_d, st_q;

    logic [N_BASE*N_REQ-1:0]    act_map;
    logic [N_BASE*N_REQ*CW-1:0] excl_flat;
    logic [N_BASE*CW-1:0]       total_flat;
    logic [N_BASE*DW-1:0]       eff_flat;
    logic [CW-1:0]              prefix_sel [N_REQ];
    logic [IW-1:0]              idx_of     [N_REQ];

    psu_route #(
        .N_REQ (N_REQ),
        .N_BASE(N_BASE),
        .IW    (IW)
    ) route_i (
        .req_valid(req_valid),
        .req_idx  (req_idx),
        .req_inc  (req_inc),
        .act_map  (act_map)
    );

    generate
        for (genvar k = 0; k < N_BASE; k++) begin : g_lane
            psu_lane #(
                .N_REQ(N_REQ),
                .CW   (CW),
                .TREE (TREE)
            ) lane_i (
                .act  (act_map[k*N_REQ +: N_REQ]),
                .excl (excl_flat[k*N_REQ*CW +: N_REQ*CW]),
                .total(total_flat[k*CW +: CW])
            );
        end
    endgenerate

    psu_bank #(
        .N_BASE(N_BASE),
        .DW    (DW),
        .IW    (IW),
        .CW    (CW)
    ) bank_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .total_flat(total_flat),
        .eff_flat  (eff_flat)
    );

    always_comb begin
        st_d      = st_q;
        st_d.live = 1'b1;
        st_d.vld  = req_valid;
        for (int i = 0; i < N_REQ; i++) begin
            idx_of[i]     = req_idx[i*IW +: IW];
            prefix_sel[i] = excl_flat[(32'(idx_of[i])*N_REQ + i)*CW +: CW];
            st_d.val[i]   = req_valid[i]
                            ? eff_flat[32'(idx_of[i])*DW +: DW] + DW'(prefix_sel[i])
                            : st_q.val[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rsp_valid = st_q.vld;
        for (int i = 0; i < N_REQ; i++) begin
            rsp_val[i*DW +: DW] = st_q.val[i];
        end
    end

    generate
        for (genvar i = 0; i < N_REQ; i++) begin : g_req_chk
            assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
                st_q.live |-> rsp_valid[i] == $past(req_valid[i]));

            assert_write_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (st_q.live && $past(wr_en && req_valid[i] && idx_of[i] == wr_idx))
                |-> rsp_val[i*DW +: DW] == DW'($past(wr_data) + DW'($past(prefix_sel[i]))));

            for (genvar j = i + 1; j < N_REQ; j++) begin : g_pair
                assert_distinct_R4: assert property (@(posedge clk) disable iff (!rst_n)
                    (st_q.live && $past(req_valid[i] && req_valid[j] && req_inc[i]
                                        && req_inc[j] && idx_of[i] == idx_of[j]))
                    |-> rsp_val[i*DW +: DW] != rsp_val[j*DW +: DW]);
            end
        end
    endgenerate

endmodule

// File: tb/psu_combine_top_tb_top.sv
`timescale 1ns/1ps
module psu_combine_top_tb_top;

    localparam int NR = 8;
    localparam int NB = 4;
    localparam int DW = 16;
    localparam int IW = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NR-1:0]     req_valid = '0;
    logic [NR*IW-1:0]  req_idx = '0;
    logic [NR-1:0]     req_inc = '0;
    logic              wr_en = 1'b0;
    logic [IW-1:0]     wr_idx = '0;
    logic [DW-1:0]     wr_data = '0;
    logic [NR-1:0]     rsp_valid;
    logic [NR*DW-1:0]  rsp_val;

    int unsigned n_cmp = 0;
    int unsigned n_bad = 0;
    bit          done  = 1'b0;

    logic [DW-1:0] model [NB];

    always #2 clk = ~clk;

    psu_combine_top #(
        .N_REQ (NR),
        .N_BASE(NB),
        .DW    (DW)
    ) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_idx  (req_idx),
        .req_inc  (req_inc),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .rsp_valid(rsp_valid),
        .rsp_val  (rsp_val)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    function automatic logic [NR*IW-1:0] all_to(input int k);
        logic [NR*IW-1:0] r;
        for (int i = 0; i < NR; i++) r[i*IW +: IW] = IW'(k);
        return r;
    endfunction

    // Drives one request cycle at a falling edge, checks the responses one cycle later.
    task automatic run_cycle(input logic [NR-1:0] v, input logic [NR*IW-1:0] ix,
                             input logic [NR-1:0] inc, input logic we,
                             input logic [IW-1:0] wi, input logic [DW-1:0] wd,
                             input string tag);
        logic [DW-1:0] effm [NB];
        logic [DW-1:0] cnt  [NB];
        logic [DW-1:0] exp_val [NR];
        for (int k = 0; k < NB; k++) begin
            effm[k] = (we && wi == IW'(k)) ? wd : model[k];
            cnt[k]  = '0;
        end
        for (int i = 0; i < NR; i++) begin
            exp_val[i] = '0;
            if (v[i]) begin
                int k;
                k = int'(ix[i*IW +: IW]);
                exp_val[i] = effm[k] + cnt[k];
                if (inc[i]) cnt[k] = cnt[k] + 1'b1;
            end
        end
        for (int k = 0; k < NB; k++) model[k] = effm[k] + cnt[k];
        req_valid = v; req_idx = ix; req_inc = inc;
        wr_en = we; wr_idx = wi; wr_data = wd;
        @(negedge clk);
        req_valid = '0; req_inc = '0; wr_en = 1'b0;
        chk({tag, " R7 valid"}, 32'(rsp_valid), 32'(v));
        for (int i = 0; i < NR; i++) begin
            if (v[i]) chk(tag, 32'(rsp_val[i*DW +: DW]), 32'(exp_val[i]));
        end
    endtask

    // Reads every base with zero-increment requests.
    task automatic read_all(input string tag);
        logic [NR*IW-1:0] ix;
        ix = '0;
        for (int k = 0; k < NB; k++) ix[k*IW +: IW] = IW'(k);
        run_cycle(NR'((1 << NB) - 1), ix, '0, 1'b0, '0, '0, tag);
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < NB; k++) model[k] = '0;
        void'($urandom(32'h5eed));
        repeat (3) @(negedge clk);
        chk("R1 rsp_valid in reset", 32'(rsp_valid), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rsp_valid after reset", 32'(rsp_valid), 32'h0);
        read_all("R1 bases zero");

        // R2: single request
        run_cycle(8'b0000_0100, all_to(2), 8'b0000_0100, 1'b0, '0, '0, "R2 single");
        read_all("R2 base moved");

        // R3 / R4: every requester on one base
        run_cycle(8'hFF, all_to(1), 8'hFF, 1'b0, '0, '0, "R3 full burst");
        for (int i = 0; i < NR; i++) begin
            for (int j = i + 1; j < NR; j++) begin
                chk("R4 distinct", 32'(rsp_val[i*DW +: DW] != rsp_val[j*DW +: DW]), 32'd1);
            end
        end
        read_all("R3 base after burst");

        // R9: zero increments mixed in
        run_cycle(8'hFF, all_to(3), 8'b1010_0110, 1'b0, '0, '0, "R9 mixed inc");
        run_cycle(8'h0F, all_to(0), 8'h00, 1'b0, '0, '0, "R9 all zero inc");
        read_all("R9 base after");

        // R5: different bases in one cycle
        begin
            logic [NR*IW-1:0] ix;
            for (int i = 0; i < NR; i++) ix[i*IW +: IW] = IW'(i % NB);
            run_cycle(8'hFF, ix, 8'hFF, 1'b0, '0, '0, "R5 spread");
            read_all("R5 bases after");
        end

        // R6: write collides with requests
        run_cycle(8'b0111_0000, all_to(2), 8'b0101_0000, 1'b1, 2'd2, 16'h1234, "R6 write+req");
        read_all("R6 base after write");
        run_cycle(8'b0000_0011, all_to(0), 8'b0000_0011, 1'b1, 2'd3, 16'h0042, "R6 write other base");
        read_all("R6 other bases");

        // R8: wrap around
        run_cycle('0, '0, '0, 1'b1, 2'd1, 16'hFFFE, "R8 preload");
        run_cycle(8'h0F, all_to(1), 8'h0F, 1'b0, '0, '0, "R8 wrap");
        chk("R8 wrapped value", 32'(rsp_val[3*DW +: DW]), 32'h0001);
        read_all("R8 base after wrap");

        // R7: invalid requests with increment set change nothing
        run_cycle(8'h00, all_to(0), 8'hFF, 1'b0, '0, '0, "R7 invalid");
        read_all("R7 bases unchanged");
        run_cycle(8'h00, '0, '0, 1'b0, '0, '0, "R7 idle");

        // Random traffic
        for (int n = 0; n < 400; n++) begin
            logic [NR-1:0]    v;
            logic [NR*IW-1:0] ix;
            logic [NR-1:0]    inc;
            logic             we;
            v   = NR'($urandom);
            ix  = (n % 3 == 0) ? all_to(int'($urandom % NB)) : (NR*IW)'($urandom);
            inc = NR'($urandom);
            we  = ($urandom % 8) == 0;
            run_cycle(v, ix, inc, we, IW'($urandom), DW'($urandom), "R3 random");
        end
        read_all("R3 final bases");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule